// File: doc/BRIEF.md
# Four-Phase Handshake Relay Controller

This controller links two four-phase (return-to-zero) handshake channels. On the upstream side it is passive: it receives a request and returns an acknowledge. On the downstream side it is active: it issues a request and waits for an acknowledge. When an upstream request arrives, the controller starts a complete handshake on the downstream channel. It acknowledges upstream only after the downstream request and acknowledge have both returned low. It then waits for the upstream request to fall, drops its acknowledge and is ready again.

The sequence runs through four states in a fixed cycle. In each state exactly one input transition is legal. Both inputs are assumed to be already synchronised to the clock. The environment presents one transition at a time and waits for the controller to respond before it presents the next. Any transition that is not the one awaited latches a protocol-error flag. That flag stays set until reset, and the offending cycle causes no state change. Both handshake outputs come straight from flip-flops.

Top module: `hs_relay`

## Requirements
- R1: While rst is high, and on the first clock after it, up_ack, dn_req and proto_err are all 0.
- R2: In the idle state, a rising up_req raises dn_req. up_ack stays low.
- R3: While dn_req is high, a rising dn_ack lowers dn_req.
- R4: After dn_req has fallen, a falling dn_ack raises up_ack.
- R5: While up_ack is high, a falling up_req lowers up_ack and returns to idle, so the next rising up_req starts a new relay cycle.
- R6: Suppose an input changes before clock edge k. It is sampled at edge k, and the resulting output change becomes visible after edge k+1. Between edges k and k+1 the outputs still hold their old values.
- R7: A change on up_req or dn_ack that the current state does not await sets proto_err after edge k+1 and leaves up_ack and dn_req unchanged. This also applies when such a change arrives in the same cycle as the awaited one.
- R8: proto_err stays high until rst is asserted. Reset clears it.
- R9: up_ack and dn_req are never high together, and they never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request (synchronised) |
| up_ack | output | 1 | Upstream acknowledge, registered |
| dn_req | output | 1 | Downstream request, registered |
| dn_ack | input | 1 | Downstream acknowledge (synchronised) |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The four states are visible only through the two handshake outputs and the error flag. A wrong internal state therefore shows up as an output that rises or falls at the wrong step of the sequence, or as proto_err being raised for a legal transition. Each such fault appears after the second clock edge following the input change. The bench checks both that edge and the interval just before it. Illegal and simultaneous transitions are injected in several states to show that they leave the outputs frozen and that the flag persists until reset.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DN_REQ = 2'd1,
    ST_DN_REL = 2'd2,
    ST_UP_ACK = 2'd3
  } relay_st_t;

  localparam int NUM_IN = 2;
  localparam int IDX_UP = 0;
  localparam int IDX_DN = 1;
endpackage

// File: rtl/hs_relay_edge.sv
module hs_relay_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] smp_q;
  logic [W-1:0] prv_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q[g] <= 1'b0;
        prv_q[g] <= 1'b0;
      end else begin
        smp_q[g] <= lvl_i[g];
        prv_q[g] <= smp_q[g];
      end
    end
    assign rise_o[g] = smp_q[g] & ~prv_q[g];
    assign fall_o[g] = ~smp_q[g] & prv_q[g];
  end
endmodule

// File: rtl/hs_relay_seq.sv
module hs_relay_seq
  import hs_relay_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] rise_i,
  input  logic [NUM_IN-1:0] fall_i,
  output logic              up_ack_o,
  output logic              dn_req_o,
  output logic              err_o
);
  relay_st_t st_q, st_d;
  logic      wanted;
  logic      any_ev;
  logic      bad_ev;
  logic      ack_q, req_q, err_q;

  always_comb begin
    wanted = 1'b0;
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE:   begin wanted = rise_i[IDX_UP]; st_d = ST_DN_REQ; end
      ST_DN_REQ: begin wanted = rise_i[IDX_DN]; st_d = ST_DN_REL; end
      ST_DN_REL: begin wanted = fall_i[IDX_DN]; st_d = ST_UP_ACK; end
      ST_UP_ACK: begin wanted = fall_i[IDX_UP]; st_d = ST_IDLE;   end
      default:   begin wanted = 1'b0;           st_d = ST_IDLE;   end
    endcase
  end

  assign any_ev = |{rise_i, fall_i};
  assign bad_ev = any_ev && !(wanted && ($countones({rise_i, fall_i}) == 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else if (bad_ev) begin
      err_q <= 1'b1;
    end else if (wanted) begin
      st_q  <= st_d;
      req_q <= (st_d == ST_DN_REQ);
      ack_q <= (st_d == ST_UP_ACK);
    end
  end

  assign up_ack_o = ack_q;
  assign dn_req_o = req_q;
  assign err_o    = err_q;
endmodule

// File: rtl/hs_relay.sv
module hs_relay
  import hs_relay_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  output logic up_ack,
  output logic dn_req,
  input  logic dn_ack,
  output logic proto_err
);
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] rise;
  logic [NUM_IN-1:0] fall;

  assign lvl[IDX_UP] = up_req;
  assign lvl[IDX_DN] = dn_ack;

  hs_relay_edge #(.W(NUM_IN)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  hs_relay_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (rise),
    .fall_i   (fall),
    .up_ack_o (up_ack),
    .dn_req_o (dn_req),
    .err_o    (proto_err)
  );
endmodule

// File: rtl/hs_relay_chk.sv
module hs_relay_chk (
  input logic clk,
  input logic rst,
  input logic up_req,
  input logic up_ack,
  input logic dn_req,
  input logic dn_ack,
  input logic proto_err
);
  // R9
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(up_ack && dn_req));
  // R9
  assert_one_change_R9: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(up_ack) && !$stable(dn_req)));
  // R2 / R6
  assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> $past(up_req, 2));
  // R3
  assert_req_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_req) |-> $past(dn_ack, 2));
  // R4
  assert_ack_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(up_ack) |-> !$past(dn_ack, 2));
  // R5
  assert_ack_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(up_ack) |-> !$past(up_req, 2));
  // R7
  assert_err_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> ($stable(up_ack) && $stable(dn_req)));
  // R8
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind hs_relay hs_relay_chk u_chk (.*);

// File: tb/sim_hs_relay.sv
`timescale 1ns/1ps
module sim_hs_relay;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0;
  logic dn_ack = 1'b0;
  logic up_ack, dn_req, proto_err;

  int checks = 0;
  int errors = 0;
  logic [2:0] qv[$];
  string      qt[$];
  logic [2:0] cur = 3'b000; // {up_ack, dn_req, proto_err}
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hs_relay u0 (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard items against outputs
  initial begin
    forever begin
      @(negedge clk);
      while (qv.size() > 0) begin
        logic [2:0] e;
        string t;
        e = qv.pop_front();
        t = qt.pop_front();
        chk(t, {up_ack, dn_req, proto_err}, e);
      end
    end
  end

  // driver: drive at negedge, expect old outputs after edge k, new after k+1 (R6)
  task automatic step(input logic ar, input logic ba, input logic [2:0] nxt, input string tag);
    @(negedge clk);
    up_req = ar;
    dn_ack = ba;
    @(posedge clk);
    qv.push_back(cur); qt.push_back({"R6 hold ", tag});
    @(posedge clk);
    qv.push_back(nxt); qt.push_back(tag);
    cur = nxt;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_req = 1'b0; dn_ack = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset values", {up_ack, dn_req, proto_err}, 3'b000);
    rst = 1'b0;
    cur = 3'b000;
    @(negedge clk);
    chk("R1 after release", {up_ack, dn_req, proto_err}, 3'b000);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 3'b010, "R2 up_req rise raises dn_req");
      step(1, 1, 3'b000, "R3 dn_ack rise lowers dn_req");
      step(1, 0, 3'b100, "R4 dn_ack fall raises up_ack");
      step(0, 0, 3'b000, "R5 up_req fall lowers up_ack");
    end
    // unexpected dn_ack rise in idle
    step(0, 1, 3'b001, "R7 dn_ack rise in idle");
    step(0, 0, 3'b001, "R8 flag held");
    step(1, 0, 3'b011, "R8 flag held while relay proceeds");
    do_reset();
    // simultaneous awaited + unexpected
    step(1, 1, 3'b001, "R7 simultaneous edges no transition");
    do_reset();
    // unexpected up_req fall while dn_req high
    step(1, 0, 3'b010, "R2 second run");
    step(0, 0, 3'b011, "R7 up_req fall while dn_req high");
    step(0, 1, 3'b001, "R3 after error");
    step(0, 0, 3'b101, "R4 after error");
    do_reset();
    // unexpected up_req fall while waiting for dn_ack fall
    step(1, 0, 3'b010, "R2 third run");
    step(1, 1, 3'b000, "R3 third run");
    step(0, 1, 3'b001, "R7 up_req fall in release state");
    do_reset();
    // unexpected dn_ack rise while up_ack high
    step(1, 0, 3'b010, "R2 fourth run");
    step(1, 1, 3'b000, "R3 fourth run");
    step(1, 0, 3'b100, "R4 fourth run");
    step(1, 1, 3'b101, "R7 dn_ack rise while up_ack high");
    do_reset();
    step(1, 0, 3'b010, "R5 fresh cycle after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule